// File: doc/BRIEF.md
# Windowed Service-Key Watchdog

This block is a watchdog counter that asks the rest of the system for a reset unless software proves it is alive. Software proves this by writing a two-byte key to a service register. The counter advances on one of two clock-enable inputs. One is a slow periodic tick and the other is the bus-rate enable. It counts up to a parameterised timeout. If the timeout is reached without a valid key, the block raises a one-cycle reset request and the count starts again.

A configuration register holds two bits that lock on the first write after reset. One bit selects the tick source. The other turns on windowed servicing. In windowed mode the key is accepted only during the final quarter of the timeout period. Any write to the service register before that point is treated as a fault and raises a reset request at once. A two-bit status output records which of the two causes produced the most recent request. This status is cleared only by the asynchronous system reset input.

The block sits between a simple register write port and the chip's reset controller. It does not generate the tick sources, and it does not sequence the system reset itself.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, `rst_req`, `cause_timeout` and `cause_window` are low. The configuration is the slow tick in normal mode, so `bus_tick` pulses do not advance the count.
- R2: A write to address 0 loads the configuration. Bit 0 selects the tick: 0 is `slow_tick` and 1 is `bus_tick`. Bit 1 enables windowed mode. Only the first write to address 0 after reset takes effect. Every later write to address 0 is ignored.
- R3: The count advances by one on each cycle in which the selected tick is high. On the TIMEOUT-th tick without service, `rst_req` is high for exactly one cycle, starting in the cycle after that tick's clock edge. Counting then restarts from zero.
- R4: Writing 0x55 and then 0xAA to address 1 is a valid service. It clears the count, so the next timeout needs a full TIMEOUT ticks. A valid service never raises a reset request.
- R5: If the write after 0x55 is any value other than 0xAA (or 0x55), the sequence is abandoned and the count is not cleared. A 0xAA that does not follow 0x55 is ignored. In normal mode neither of these raises a reset request.
- R6: In windowed mode, any write to address 1 while the count is below TIMEOUT - TIMEOUT/4 raises a one-cycle reset request. It also sets `cause_window`, restarts the count and drops any half-entered key.
- R7: In windowed mode, a key written while the count is at or above TIMEOUT - TIMEOUT/4 is accepted exactly as in R4.
- R8: Each reset request sets exactly one cause bit: `cause_timeout` for a timeout and `cause_window` for an early service write. It clears the other bit. Both bits hold their values until the next request or until `rst_n` is asserted.
- R9: A valid service whose 0xAA write lands in the same cycle as the terminal tick takes priority. No request is raised, and the count clears.
- R10: Writes to addresses 2 and 3 have no effect. They neither service the counter, nor count as early service writes, nor lock the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address: 0 configuration, 1 service key |
| wr_data | input | 8 | Write data |
| slow_tick | input | 1 | Slow periodic count enable |
| bus_tick | input | 1 | Bus-rate count enable |
| rst_req | output | 1 | One-cycle reset request to the reset controller |
| cause_timeout | output | 1 | Last request came from a timeout |
| cause_window | output | 1 | Last request came from an early service write |

## Verification
The hardest situations to reach from the ports sit at exact count values. These are the last early count and the first in-window count of the service window, and the cycle in which the closing key byte meets the terminal tick. The bench can only infer the count from when requests appear. It therefore drives every tick as an isolated one-cycle pulse and places register writes in tick-free cycles, so the count at each write is known exactly. It then sweeps the service point over every count of a small timeout in both modes. For the tie case it drives the closing 0xAA and the terminal tick on the same edge.

// File: rtl/svc_watchdog_pkg.sv
package svc_watchdog_pkg;

  localparam int unsigned DATA_W = 8;

  // Service key bytes, in the order they must arrive
  localparam logic [DATA_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_FIRE = 8'hAA;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;

  // Packed so that bit 0 is the tick select and bit 1 the window enable
  typedef struct packed {
    logic win_en;
    logic bus_sel;
  } wdt_cfg_t;

  localparam int unsigned CFG_W = $bits(wdt_cfg_t);

endpackage

// File: rtl/svc_watchdog_cfg.sv
module svc_watchdog_cfg
  import svc_watchdog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ni,
  input  logic     cfg_wr,
  input  wdt_cfg_t cfg_in,
  output wdt_cfg_t cfg_q,
  output logic     locked_q
);

  wdt_cfg_t cfg_d;
  logic     locked_d;

  always_comb begin
    cfg_d    = cfg_q;
    locked_d = locked_q;
    if (cfg_wr && !locked_q) begin
      cfg_d    = cfg_in;
      locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      locked_q <= locked_d;
    end
  end

endmodule

// File: rtl/svc_watchdog_key.sv
module svc_watchdog_key
  import svc_watchdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              svc_wr,
  input  logic [DATA_W-1:0] svc_data,
  input  logic              block,     // write rejected by the window check
  input  logic              abort,     // any reset request this cycle
  output logic              svc_done
);

  key_state_e state_q, state_d;

  // Kept apart from the next-state process: the timer uses svc_done to
  // decide the abort that feeds back into the next state.
  assign svc_done = svc_wr && !block && (state_q == KEY_ARMED) &&
                    (svc_data == KEY_FIRE);

  always_comb begin
    state_d = state_q;
    if (svc_wr && !block) begin
      unique case (state_q)
        KEY_IDLE:  if (svc_data == KEY_ARM) state_d = KEY_ARMED;
        KEY_ARMED: state_d = (svc_data == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
        default:   state_d = KEY_IDLE;
      endcase
    end
    if (abort) state_d = KEY_IDLE;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/svc_watchdog_timer.sv
module svc_watchdog_timer #(
  parameter int unsigned TIMEOUT = 1024,
  localparam int unsigned CNT_W     = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1,
  localparam int unsigned WIN_START = TIMEOUT - TIMEOUT / 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  input  logic             win_en,
  input  logic             svc_wr,
  input  logic             svc_done,
  output logic             violate_ev,
  output logic             timeout_ev,
  output logic [CNT_W-1:0] count_q
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0] OPEN_CNT = CNT_W'(WIN_START);

  logic [CNT_W-1:0] count_d;
  logic             early;

  assign early      = count_q < OPEN_CNT;
  assign violate_ev = win_en && svc_wr && early;
  // A key completing on the terminal tick wins over the timeout
  assign timeout_ev = tick && (count_q == LAST_CNT) && !svc_done;

  always_comb begin
    count_d = count_q;
    if (violate_ev || timeout_ev || svc_done) count_d = '0;
    else if (tick)                            count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

endmodule

// File: rtl/svc_watchdog_status.sv
module svc_watchdog_status (
  input  logic clk,
  input  logic rst_ni,
  input  logic timeout_ev,
  input  logic violate_ev,
  output logic req_q,
  output logic cause_to_q,
  output logic cause_win_q
);

  logic req_d, cause_to_d, cause_win_d;

  always_comb begin
    req_d       = timeout_ev || violate_ev;
    cause_to_d  = cause_to_q;
    cause_win_d = cause_win_q;
    if (violate_ev) begin
      cause_to_d  = 1'b0;
      cause_win_d = 1'b1;
    end else if (timeout_ev) begin
      cause_to_d  = 1'b1;
      cause_win_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q       <= 1'b0;
      cause_to_q  <= 1'b0;
      cause_win_q <= 1'b0;
    end else begin
      req_q       <= req_d;
      cause_to_q  <= cause_to_d;
      cause_win_q <= cause_win_d;
    end
  end

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_watchdog_pkg::*;
#(
  parameter int unsigned TIMEOUT     = 1024,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned CFG_ADDR    = 0,
  parameter int unsigned SVC_ADDR    = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              slow_tick,
  input  logic              bus_tick,
  output logic              rst_req,
  output logic              cause_timeout,
  output logic              cause_window
);

  localparam int unsigned CNT_W     = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam int unsigned WIN_START = TIMEOUT - TIMEOUT / 4;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_sync_n;
  generate
    if (SYNC_STAGES <= 1) begin : g_sync_one
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= 1'b1;
      end
      assign rst_sync_n = stage_q;
    end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = stage_q[SYNC_STAGES-1];
    end
  endgenerate

  logic cfg_wr, svc_wr;
  assign cfg_wr = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
  assign svc_wr = wr_en && (wr_addr == ADDR_W'(SVC_ADDR));

  wdt_cfg_t cfg_q;
  logic     cfg_locked;

  svc_watchdog_cfg u_cfg (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .cfg_wr   (cfg_wr),
    .cfg_in   (wdt_cfg_t'(wr_data[CFG_W-1:0])),
    .cfg_q    (cfg_q),
    .locked_q (cfg_locked)
  );

  logic tick, win_en;
  assign tick   = cfg_q.bus_sel ? bus_tick : slow_tick;
  assign win_en = cfg_q.win_en;

  logic             svc_done, violate_ev, timeout_ev;
  logic [CNT_W-1:0] count;

  svc_watchdog_key u_key (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .svc_wr   (svc_wr),
    .svc_data (wr_data),
    .block    (violate_ev),
    .abort    (violate_ev || timeout_ev),
    .svc_done (svc_done)
  );

  svc_watchdog_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .tick       (tick),
    .win_en     (win_en),
    .svc_wr     (svc_wr),
    .svc_done   (svc_done),
    .violate_ev (violate_ev),
    .timeout_ev (timeout_ev),
    .count_q    (count)
  );

  svc_watchdog_status u_status (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .timeout_ev  (timeout_ev),
    .violate_ev  (violate_ev),
    .req_q       (rst_req),
    .cause_to_q  (cause_timeout),
    .cause_win_q (cause_window)
  );

endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned WIN_START = 768
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             rst_req,
  input logic             cause_timeout,
  input logic             cause_window,
  input logic             cfg_locked,
  input logic [1:0]       cfg_bits,
  input logic             win_en,
  input logic             svc_wr,
  input logic             svc_done,
  input logic [CNT_W-1:0] count
);

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_req |=> !rst_req);

  assert_cause_onehot_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({cause_timeout, cause_window}));

  assert_cause_with_req_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_req |-> ($countones({cause_timeout, cause_window}) == 1));

  assert_cause_hold_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !rst_req |-> $stable({cause_timeout, cause_window}));

  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_locked |=> (cfg_locked && $stable(cfg_bits)));

  assert_early_write_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (win_en && svc_wr && (count < CNT_W'(WIN_START))) |=>
      (rst_req && cause_window && (count == '0)));

  assert_service_clears_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    svc_done |=> (!rst_req && (count == '0)));

endmodule

bind svc_watchdog svc_watchdog_chk #(
  .CNT_W     (CNT_W),
  .WIN_START (WIN_START)
) u_chk (
  .clk           (clk),
  .rst_ni        (rst_sync_n),
  .rst_req       (rst_req),
  .cause_timeout (cause_timeout),
  .cause_window  (cause_window),
  .cfg_locked    (cfg_locked),
  .cfg_bits      (cfg_q),
  .win_en        (win_en),
  .svc_wr        (svc_wr),
  .svc_done      (svc_done),
  .count         (count)
);

// File: tb/svc_watchdog_test.sv
`timescale 1ns/1ps
module svc_watchdog_test;

  localparam int TO = 8;
  localparam int WS = TO - TO / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       slow_tick = 1'b0;
  logic       bus_tick = 1'b0;
  logic       rst_req, cause_timeout, cause_window;

  always #4 clk = ~clk;

  svc_watchdog #(.TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .slow_tick(slow_tick), .bus_tick(bus_tick),
    .rst_req(rst_req), .cause_timeout(cause_timeout), .cause_window(cause_window)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // n isolated tick pulses; counts requests seen and the tick number of the first
  task automatic ticks(input bit use_bus, input int n, output int reqs, output int first);
    reqs = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      if (use_bus) bus_tick = 1'b1; else slow_tick = 1'b1;
      @(negedge clk);
      bus_tick = 1'b0; slow_tick = 1'b0;
      if (rst_req) begin reqs++; if (first == 0) first = i; end
      @(negedge clk);
      if (rst_req) reqs++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int r, f, acc;
    @(negedge clk);

    // R1 reset state and default tick source
    do_reset();
    chk("R1 rst_req after reset", rst_req, 0);
    chk("R1 cause_timeout after reset", cause_timeout, 0);
    chk("R1 cause_window after reset", cause_window, 0);
    ticks(1'b1, 3 * TO, r, f);
    chk("R1 bus_tick ignored by default", r, 0);

    // R3 plain timeout, single pulse, restart
    ticks(1'b0, TO, r, f);
    chk("R3 timeout tick index", f, TO);
    chk("R3 one-cycle request", r, 1);
    chk("R8 timeout cause set", cause_timeout, 1);
    chk("R8 window cause clear", cause_window, 0);
    ticks(1'b0, TO, r, f);
    chk("R3 restart after timeout", f, TO);

    // R4 normal-mode service at every count
    for (int d = 0; d < TO; d++) begin
      do_reset();
      wr(2'd0, 8'h00);
      ticks(1'b0, d, r, f);
      chk("R4 no request before service", r, 0);
      acc = 0;
      wr(2'd1, 8'h55); acc += int'(rst_req);
      wr(2'd1, 8'hAA); acc += int'(rst_req);
      chk("R4 no request from service", acc, 0);
      ticks(1'b0, TO, r, f);
      chk("R4 full period after service", f, TO);
    end

    // R6 / R7 windowed service at every count
    for (int d = 0; d < TO; d++) begin
      do_reset();
      wr(2'd0, 8'h02);
      ticks(1'b0, d, r, f);
      wr(2'd1, 8'h55);
      if (d < WS) begin
        chk("R6 early key write requests reset", rst_req, 1);
        chk("R6 window cause", cause_window, 1);
        chk("R6 timeout cause clear", cause_timeout, 0);
        ticks(1'b0, TO, r, f);
        chk("R6 count restarted", f, TO);
        chk("R8 timeout replaces window cause", int'(cause_timeout && !cause_window), 1);
      end else begin
        chk("R7 in-window first byte", rst_req, 0);
        wr(2'd1, 8'hAA);
        chk("R7 in-window second byte", rst_req, 0);
        ticks(1'b0, TO, r, f);
        chk("R7 service accepted", f, TO);
      end
    end

    // R6 any value counts as an early write
    do_reset();
    wr(2'd0, 8'h02);
    ticks(1'b0, 2, r, f);
    wr(2'd1, 8'h3C);
    chk("R6 non-key early write", rst_req, 1);
    do_reset();
    chk("R8 cleared by rst_n (timeout)", cause_timeout, 0);
    chk("R8 cleared by rst_n (window)", cause_window, 0);

    // R5 abandoned sequence and stray second byte
    do_reset();
    wr(2'd0, 8'h00);
    ticks(1'b0, 3, r, f);
    acc = 0;
    wr(2'd1, 8'h55); acc += int'(rst_req);
    wr(2'd1, 8'h12); acc += int'(rst_req);
    wr(2'd1, 8'hAA); acc += int'(rst_req);
    chk("R5 abandoned sequence raises nothing", acc, 0);
    ticks(1'b0, TO, r, f);
    chk("R5 abandoned sequence kept count", f, TO - 3);
    do_reset();
    wr(2'd0, 8'h00);
    ticks(1'b0, 2, r, f);
    wr(2'd1, 8'hAA);
    chk("R5 lone second byte raises nothing", rst_req, 0);
    ticks(1'b0, TO, r, f);
    chk("R5 lone second byte kept count", f, TO - 2);

    // R2 write-once configuration
    do_reset();
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h01);
    ticks(1'b1, 2 * TO, r, f);
    chk("R2 later tick select ignored", r, 0);
    ticks(1'b0, 1, r, f);
    wr(2'd1, 8'h55);
    chk("R2 window mode kept", rst_req, 1);
    do_reset();
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);
    ticks(1'b0, 2 * TO, r, f);
    chk("R2 slow tick ignored with bus select", r, 0);
    ticks(1'b1, TO, r, f);
    chk("R2 bus tick drives count", f, TO);

    // R9 closing byte on the terminal tick
    do_reset();
    wr(2'd0, 8'h00);
    ticks(1'b0, TO - 1, r, f);
    wr(2'd1, 8'h55);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'hAA; slow_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; slow_tick = 1'b0;
    chk("R9 service beats terminal tick", rst_req, 0);
    ticks(1'b0, TO, r, f);
    chk("R9 count cleared on tie", f, TO);

    // R10 unused addresses
    do_reset();
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h02);
    ticks(1'b0, 1, r, f);
    wr(2'd2, 8'h55);
    chk("R10 unused address not a service write", rst_req, 0);
    wr(2'd1, 8'h55);
    chk("R10 unused address did not lock config", rst_req, 1);
    do_reset();
    wr(2'd0, 8'h00);
    ticks(1'b0, 3, r, f);
    wr(2'd2, 8'h55);
    wr(2'd1, 8'hAA);
    ticks(1'b0, TO, r, f);
    chk("R10 unused address does not arm key", f, TO - 3);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule